// File: doc/BRIEF.md
# Power-Good Hysteretic Delay Monitor

This block drives an active-low power-good flag for a switched supply output. Each cycle it takes a sampled digital code for the input voltage and one for the output voltage, plus a switch-enable level. It compares the output against two fixed fractions of the input to get a hysteresis band. The upper fraction (90%) opens a qualification window. The flag asserts only after that window has lasted a set number of timebase ticks, which stand for 40 ms at a 1 ms tick. The lower fraction (85%) drops the flag again. Any disable of the switch releases the flag at once, without waiting for a clock edge.

The pull-down output `pg_n_o` is meant to drive an open-drain pad. Low means the output is good and high means it is not. Each ratio test is done by cross-multiplying integers, so the block needs no divider. A three-state machine controls the flag:

- `ST_IDLE`: flag released.
- `ST_QUAL`: qualification window running.
- `ST_GOOD`: flag asserted.

Its transitions are:

- `ST_IDLE` to `ST_QUAL` on start.
- `ST_QUAL` to `ST_GOOD` on elapse.
- `ST_QUAL` to `ST_IDLE` on abort or disable.
- `ST_GOOD` to `ST_IDLE` on sag or disable.

Top module: `pwr_good_mon`

## Requirements
- R1: After reset, `pg_n_o` is 1 (not good) and the machine is in `ST_IDLE`.
- R2: `pg_n_o` is active low: 0 means power good and 1 means not good.
- R3: Qualification starts only when `sw_en_i` is 1 and DEN*vout > HI*vin (DEN=100, HI=90). An output at exactly 90% of the input does not start it.
- R4: The flag asserts at the clock edge that follows the DELAY_TICKS-th `tick_i` pulse seen while in `ST_QUAL`. Ticks seen before qualification starts are not counted.
- R5: If the output falls to or below 90% during qualification, the machine returns to `ST_IDLE` and the tick count is discarded. A later attempt needs the full DELAY_TICKS again.
- R6: While good, DEN*vout < LO*vin (LO=85) releases the flag one cycle later. An output at exactly 85% keeps it asserted.
- R7: Between 85% and 90% inclusive, the flag keeps its present state. From the released state, such an output never starts qualification.
- R8: `sw_en_i` low forces `pg_n_o` to 1 in the same cycle, before any clock edge. On re-enable, full qualification is needed before the flag asserts again.
- R9: While `sw_en_i` is 0, no output level and no number of ticks asserts the flag.
- R10: Both thresholds follow the input code: the same rules hold when `vin_code_i` is changed to a different value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle timebase strobe for the qualification delay |
| sw_en_i | input | 1 | Switch enable level, 1 = switch on |
| vin_code_i | input | W | Sampled input-voltage code |
| vout_code_i | input | W | Sampled output-voltage code |
| pg_n_o | output | 1 | Active-low power-good pull-down control |

## Verification
The hardest case to reach from the ports is an abort in the middle of the window. A partial tick count must be thrown away, so a later rise needs the whole delay again and not just the remainder. To reach it, the stimulus enters qualification, gives some but not all of the ticks, and dips the output into the band for one cycle. It then raises the output again and checks that the flag is still released one tick short of the full count. Exact 90% and 85% codes are driven to pin down which side each threshold's equality falls on. Ticks are also given before qualification starts, to show they are not counted.

// File: rtl/pg_mon_pkg.sv
package pg_mon_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_QUAL = 2'd1,
        ST_GOOD = 2'd2
    } pg_state_t;
endpackage

// File: rtl/pg_ratio_cmp.sv
module pg_ratio_cmp #(
    parameter int W   = 10,
    parameter int DEN = 100,
    parameter int HI  = 90,
    parameter int LO  = 85
) (
    input  logic [W-1:0] vin_i,
    input  logic [W-1:0] vout_i,
    output logic         above_hi_o,
    output logic         below_lo_o
);
    localparam int PW = W + $clog2(DEN + 1);

    logic [PW-1:0] scaled_out;
    logic [PW-1:0] hi_lim;
    logic [PW-1:0] lo_lim;

    always_comb begin
        scaled_out = PW'(vout_i) * PW'(DEN);
        hi_lim     = PW'(vin_i) * PW'(HI);
        lo_lim     = PW'(vin_i) * PW'(LO);
        above_hi_o = scaled_out > hi_lim;
        below_lo_o = scaled_out < lo_lim;
    end

    // band is nonempty when HI > LO: both flags never set together (R7)
    always_comb begin
        assert_band_exclusive_R7: assert (!(above_hi_o && below_lo_o));
    end
endmodule

// File: rtl/pg_qual_timer.sv
module pg_qual_timer #(
    parameter int DELAY_TICKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && tick_i && (cnt_q == LAST);

    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    assert_cnt_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/pg_ctrl_fsm.sv
module pg_ctrl_fsm
    import pg_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic above_hi_i,
    input  logic below_lo_i,
    input  logic done_i,
    output logic run_o,
    output logic pg_n_o
);
    pg_state_t state_q;
    pg_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en_i && above_hi_i) state_d = ST_QUAL;
            ST_QUAL: begin
                if (!en_i || !above_hi_i) state_d = ST_IDLE;
                else if (done_i)          state_d = ST_GOOD;
            end
            ST_GOOD: if (!en_i || below_lo_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        run_o  = (state_q == ST_QUAL);
        pg_n_o = !((state_q == ST_GOOD) && en_i);
    end

    assert_good_after_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_GOOD) |-> ($past(state_q) == ST_QUAL) && $past(done_i));

    assert_abort_to_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUAL && en_i && !above_hi_i) |=> state_q == ST_IDLE);

    assert_sag_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GOOD && below_lo_i) |=> state_q == ST_IDLE);

    assert_disable_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> state_q == ST_IDLE);

    assert_band_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GOOD && en_i && !below_lo_i) |=> state_q == ST_GOOD);
endmodule

// File: rtl/pwr_good_mon.sv
module pwr_good_mon #(
    parameter int W           = 10,
    parameter int DEN         = 100,
    parameter int HI          = 90,
    parameter int LO          = 85,
    parameter int DELAY_TICKS = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         sw_en_i,
    input  logic [W-1:0] vin_code_i,
    input  logic [W-1:0] vout_code_i,
    output logic         pg_n_o
);
    logic above_hi;
    logic below_lo;
    logic run;
    logic done;

    pg_ratio_cmp #(.W(W), .DEN(DEN), .HI(HI), .LO(LO)) u_cmp (
        .vin_i      (vin_code_i),
        .vout_i     (vout_code_i),
        .above_hi_o (above_hi),
        .below_lo_o (below_lo)
    );

    pg_qual_timer #(.DELAY_TICKS(DELAY_TICKS)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_i (tick_i),
        .done_o (done)
    );

    pg_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (sw_en_i),
        .above_hi_i (above_hi),
        .below_lo_i (below_lo),
        .done_i     (done),
        .run_o      (run),
        .pg_n_o     (pg_n_o)
    );

    assert_no_good_while_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_en_i && $past(!sw_en_i)) |-> pg_n_o);
endmodule

// File: tb/tb_pwr_good_mon.sv
module tb_pwr_good_mon;
    localparam int W  = 10;
    localparam int DT = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] vin = '0;
    logic [W-1:0] vout = '0;
    logic         pg_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwr_good_mon #(.W(W), .DELAY_TICKS(DT)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .sw_en_i     (en),
        .vin_code_i  (vin),
        .vout_code_i (vout),
        .pg_n_o      (pg_n)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            step();
            tick = 1'b0;
        end
    endtask

    task automatic check(logic act, logic exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pg_n actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        check(pg_n, 1'b1, "R1 reset state");
    endtask

    task automatic t_first_assert();
        en = 1'b1; vin = 10'd1000; vout = 10'd500;
        step();
        pulse(3);                         // ticks before qualification: ignored
        vout = 10'd950;
        step();                           // now qualifying
        pulse(DT - 1);
        check(pg_n, 1'b1, "R4 one tick short");
        pulse(1);
        check(pg_n, 1'b0, "R2 R4 asserted after full delay");
    endtask

    task automatic t_band_and_sag();
        vout = 10'd880; step(); step(); step();
        check(pg_n, 1'b0, "R7 band holds good");
        vout = 10'd850; step();
        check(pg_n, 1'b0, "R6 exactly 85% holds");
        vout = 10'd849; step();
        check(pg_n, 1'b1, "R6 below 85% releases");
        vout = 10'd880; step();
        pulse(DT + 1);
        check(pg_n, 1'b1, "R7 band never qualifies from idle");
    endtask

    task automatic t_exact_hi();
        vout = 10'd900; step();
        pulse(DT + 1);
        check(pg_n, 1'b1, "R3 exactly 90% does not qualify");
        vout = 10'd901; step();
        pulse(DT);
        check(pg_n, 1'b0, "R3 just above 90% qualifies");
    endtask

    task automatic t_disable();
        en = 1'b0;
        #1;
        check(pg_n, 1'b1, "R8 same-cycle release on disable");
        step();
        en = 1'b1; step();
        check(pg_n, 1'b1, "R8 no instant re-assert");
        pulse(DT - 1);
        check(pg_n, 1'b1, "R8 requalify short");
        pulse(1);
        check(pg_n, 1'b0, "R8 requalify complete");
    endtask

    task automatic t_abort();
        vout = 10'd800; step();
        check(pg_n, 1'b1, "R6 drop to 80%");
        vout = 10'd950; step();
        pulse(DT - 2);
        vout = 10'd890; step();           // abort edge
        vout = 10'd950; step();           // requalify start
        pulse(DT - 1);
        check(pg_n, 1'b1, "R5 partial count discarded");
        pulse(1);
        check(pg_n, 1'b0, "R5 full delay after abort");
    endtask

    task automatic t_disabled();
        en = 1'b0; vout = 10'd1000; step();
        pulse(2 * DT);
        check(pg_n, 1'b1, "R9 disabled never asserts");
    endtask

    task automatic t_ratio();
        en = 1'b1; vin = 10'd500; vout = 10'd400; step();
        pulse(DT);
        check(pg_n, 1'b1, "R10 80% of 500 stays off");
        vout = 10'd451; step();
        pulse(DT);
        check(pg_n, 1'b0, "R10 above 450 of 500 asserts");
        vout = 10'd425; step();
        check(pg_n, 1'b0, "R10 exactly 425 holds");
        vout = 10'd424; step();
        check(pg_n, 1'b1, "R10 below 425 releases");
    endtask

    initial begin
        step(); step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_first_assert();
        t_band_and_sag();
        t_exact_hi();
        t_disable();
        t_abort();
        t_disabled();
        t_ratio();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule